// File: doc/BRIEF.md
# 8-bit Accumulator Instruction Sequencer

This block is a small multi-cycle processor core. It runs a handful of 8-bit accumulator instructions over one byte-wide memory bus. Every instruction is a fixed sequence of one-byte bus cycles:

- an opcode fetch;
- zero, one or two operand fetches at the program counter;
- reads or writes of data at an effective address.

The addressing mode of the opcode picks the sequence. Sixteen-bit values always move as two byte cycles, high byte first.

After reset the core reads its start address from a two-byte vector near the top of memory. It then fetches and executes until it meets an opcode it does not know. At that point it stops and holds an error flag until the next reset.

A trace port reports each bus access one cycle after it happens. A test environment can compare the full cycle list of a program against a list it expects.

Top module: `acc8_seq_core`

## Requirements
- R1: While `rst` is high, `illegal` and `trc_valid` are 0. After `rst` falls, the first two bus cycles are reads at $FFFE and then $FFFF. The program counter becomes {byte at $FFFE, byte at $FFFF}, and execution starts there.
- R2: Every instruction starts with a read at the program counter. The byte read goes to the instruction register and the program counter then advances by one. Each operand byte is a further read at the program counter, followed by another advance of one.
- R3: Opcode $87 sets A to 0. It takes the opcode fetch plus one internal cycle with no bus access. No trace entry lies between its fetch and the next opcode fetch.
- R4: Opcode $86 loads A from the next byte. It uses exactly two bus reads.
- R5: Opcode $96 takes one operand byte nn and loads A from address $00nn.
- R6: Opcode $B6 takes two operand bytes, high byte first, as a 16-bit address. It loads A from that address.
- R7: Opcode $CE loads the 16-bit X from the two operand bytes, high byte first.
- R8: Opcode $FE takes a two-byte address E. It reads the high byte of X at E and then the low byte at E+1.
- R9: Opcode $7E takes a two-byte address E. It writes the high byte of X at E and then the low byte at E+1.
- R10: Opcode $72 takes a two-byte address E. It reads the byte at E and then writes (byte+1) mod 256 back to E.
- R11: Opcode $20 takes a signed 8-bit offset. The next opcode fetch is at the address after the offset byte plus the offset, so both forward and backward branches work.
- R12: Any other opcode stops the core after its fetch and sets `illegal` to 1. The program counter is left one past that opcode. There are no further bus cycles until reset, and reset clears the flag.
- R13: Each bus access gives exactly one cycle of `trc_valid` = 1 on the next clock. With it come that access's address, its data (read data or write data) and `trc_write` (1 = write, 0 = read).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | output | 16 | Bus address of the current cycle |
| bus_we | output | 1 | 1 when the current cycle is a write |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the same cycle as the address |
| trc_valid | output | 1 | A bus access happened in the previous cycle |
| trc_addr | output | 16 | Address of the traced access |
| trc_data | output | 8 | Data of the traced access |
| trc_write | output | 1 | Traced access was a write |
| acc_a | output | 8 | Register A |
| idx_x | output | 16 | Register X |
| prog_ctr | output | 16 | Program counter |
| illegal | output | 1 | Sticky unknown-opcode flag |

## Verification
The bench runs one short program per addressing mode and compares the full recorded cycle list, entry by entry, against a hand-derived list. Each program ends on an unknown opcode, so the cycle count is exact.

Several faults would show up in that list or in the final registers:

- A core that swapped the byte order of 16-bit moves would load X or write memory with its bytes reversed.
- A core that took the branch offset from the opcode address would land two bytes off.
- A sign-handling fault would send the backward branch forward.
- A clear-A that touched the bus would add a stray entry to the list.
- An increment that wrote the read value unchanged would leave memory at $FF instead of wrapping it to $00.
- After a halt, the bench waits further cycles to confirm the bus stays quiet and the flag holds, then confirms that reset clears it.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  localparam logic [7:0] OPC_CLRA = 8'h87;
  localparam logic [7:0] OPC_LDAI = 8'h86;
  localparam logic [7:0] OPC_LDAD = 8'h96;
  localparam logic [7:0] OPC_LDAE = 8'hB6;
  localparam logic [7:0] OPC_LDXI = 8'hCE;
  localparam logic [7:0] OPC_LDXE = 8'hFE;
  localparam logic [7:0] OPC_STXE = 8'h7E;
  localparam logic [7:0] OPC_INCE = 8'h72;
  localparam logic [7:0] OPC_BRA  = 8'h20;

  typedef enum logic [3:0] {
    C_CLRA, C_LDAI, C_LDAD, C_LDAE, C_LDXI,
    C_LDXE, C_STXE, C_INCE, C_BRA,  C_ILL
  } op_cls_t;

  typedef enum logic [3:0] {
    S_VHI, S_VLO, S_FETCH, S_INT, S_OPR1, S_OPR2,
    S_RD1, S_RD2, S_WR1, S_WR2, S_HALT
  } seq_st_t;

endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
(
  input  logic [7:0] op_i,
  output op_cls_t    cls_o
);

  always_comb begin
    unique case (op_i)
      OPC_CLRA: cls_o = C_CLRA;
      OPC_LDAI: cls_o = C_LDAI;
      OPC_LDAD: cls_o = C_LDAD;
      OPC_LDAE: cls_o = C_LDAE;
      OPC_LDXI: cls_o = C_LDXI;
      OPC_LDXE: cls_o = C_LDXE;
      OPC_STXE: cls_o = C_STXE;
      OPC_INCE: cls_o = C_INCE;
      OPC_BRA:  cls_o = C_BRA;
      default:  cls_o = C_ILL;
    endcase
  end

endmodule

// File: rtl/acc8_trace.sv
module acc8_trace #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] wdata_i,
  output logic          trc_valid,
  output logic [AW-1:0] trc_addr,
  output logic [DW-1:0] trc_data,
  output logic          trc_write
);

  always_ff @(posedge clk) begin
    if (rst) begin
      trc_valid <= 1'b0;
      trc_addr  <= '0;
      trc_data  <= '0;
      trc_write <= 1'b0;
    end else begin
      trc_valid <= act_i;
      if (act_i) begin
        trc_addr  <= addr_i;
        trc_data  <= we_i ? wdata_i : rdata_i;
        trc_write <= we_i;
      end
    end
  end

  // R13: the trace never reports an access while no bus cycle ran
  p_trace_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    !act_i |=> !trc_valid);

endmodule

// File: rtl/acc8_seq_core.sv
module acc8_seq_core
  import acc8_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFFFE
) (
  input  logic            clk,
  input  logic            rst,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_we,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  output logic            trc_valid,
  output logic [AW-1:0]   trc_addr,
  output logic [DW-1:0]   trc_data,
  output logic            trc_write,
  output logic [DW-1:0]   acc_a,
  output logic [2*DW-1:0] idx_x,
  output logic [AW-1:0]   prog_ctr,
  output logic            illegal
);

  localparam int XW = 2 * DW;
  localparam int PW = AW - DW;

  seq_st_t         st;
  op_cls_t         cls, dec_cls;
  logic [AW-1:0]   pc, ear;
  logic [DW-1:0]   tmp;
  logic            bus_act;
  logic [AW-1:0]   pc_inc;

  acc8_decode u_dec (
    .op_i  (bus_rdata),
    .cls_o (dec_cls)
  );

  assign pc_inc = pc + 1'b1;

  // bus cycle decoded from the sequencer state
  always_comb begin
    bus_act = 1'b1;
    bus_we  = 1'b0;
    unique case (st)
      S_VHI:                  bus_addr = VEC_ADDR;
      S_VLO:                  bus_addr = VEC_ADDR + 1'b1;
      S_FETCH, S_OPR1, S_OPR2: bus_addr = pc;
      S_RD1:                  bus_addr = ear;
      S_RD2:                  bus_addr = ear + 1'b1;
      S_WR1: begin            bus_addr = ear;        bus_we = 1'b1; end
      S_WR2: begin            bus_addr = ear + 1'b1; bus_we = 1'b1; end
      default: begin          bus_addr = pc;         bus_act = 1'b0; end
    endcase
    if (st == S_WR2)
      bus_wdata = idx_x[DW-1:0];
    else if (cls == C_STXE)
      bus_wdata = idx_x[XW-1:DW];
    else
      bus_wdata = tmp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_VHI;
      cls     <= C_ILL;
      pc      <= '0;
      ear     <= '0;
      tmp     <= '0;
      acc_a   <= '0;
      idx_x   <= '0;
      illegal <= 1'b0;
    end else begin
      unique case (st)
        S_VHI: begin
          tmp <= bus_rdata;
          st  <= S_VLO;
        end
        S_VLO: begin
          pc <= {tmp, bus_rdata};
          st <= S_FETCH;
        end
        S_FETCH: begin
          cls <= dec_cls;
          pc  <= pc_inc;
          if (dec_cls == C_CLRA)      st <= S_INT;
          else if (dec_cls == C_ILL) begin
            st      <= S_HALT;
            illegal <= 1'b1;
          end else                    st <= S_OPR1;
        end
        S_INT: begin
          acc_a <= '0;
          st    <= S_FETCH;
        end
        S_OPR1: begin
          unique case (cls)
            C_LDAI: begin
              acc_a <= bus_rdata;
              pc    <= pc_inc;
              st    <= S_FETCH;
            end
            C_LDXI: begin
              tmp <= bus_rdata;
              pc  <= pc_inc;
              st  <= S_OPR2;
            end
            C_LDAD: begin
              ear <= {{PW{1'b0}}, bus_rdata};
              pc  <= pc_inc;
              st  <= S_RD1;
            end
            C_BRA: begin
              pc <= pc_inc + {{PW{bus_rdata[DW-1]}}, bus_rdata};
              st <= S_FETCH;
            end
            default: begin
              ear[AW-1:DW] <= bus_rdata;
              pc           <= pc_inc;
              st           <= S_OPR2;
            end
          endcase
        end
        S_OPR2: begin
          pc <= pc_inc;
          if (cls == C_LDXI) begin
            idx_x <= {tmp, bus_rdata};
            st    <= S_FETCH;
          end else begin
            ear[DW-1:0] <= bus_rdata;
            st          <= (cls == C_STXE) ? S_WR1 : S_RD1;
          end
        end
        S_RD1: begin
          if (cls == C_LDXE) begin
            tmp <= bus_rdata;
            st  <= S_RD2;
          end else if (cls == C_INCE) begin
            tmp <= bus_rdata + 1'b1;
            st  <= S_WR1;
          end else begin
            acc_a <= bus_rdata;
            st    <= S_FETCH;
          end
        end
        S_RD2: begin
          idx_x <= {tmp, bus_rdata};
          st    <= S_FETCH;
        end
        S_WR1:   st <= (cls == C_STXE) ? S_WR2 : S_FETCH;
        S_WR2:   st <= S_FETCH;
        default: st <= S_HALT;
      endcase
    end
  end

  assign prog_ctr = pc;

  acc8_trace #(.AW(AW), .DW(DW)) u_trc (
    .clk       (clk),
    .rst       (rst),
    .act_i     (bus_act),
    .we_i      (bus_we),
    .addr_i    (bus_addr),
    .rdata_i   (bus_rdata),
    .wdata_i   (bus_wdata),
    .trc_valid (trc_valid),
    .trc_addr  (trc_addr),
    .trc_data  (trc_data),
    .trc_write (trc_write)
  );

  // R12: the unknown-opcode flag holds until reset
  p_illegal_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal);

  // R2: every opcode fetch advances the program counter by one
  p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH) |=> (pc == AW'($past(pc) + 1'b1)));

  // R3: the internal cycle of clear-A leaves A at zero
  p_clra_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_INT) |=> (acc_a == '0));

  // R9: the low byte of a 16-bit store goes one address above the high byte
  p_store_order_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_WR1 && cls == C_STXE) |=>
      (bus_we && bus_addr == AW'($past(bus_addr) + 1'b1)));

  // R10: the write-back after an increment read carries the read value plus one
  p_inc_writeback_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_RD1 && cls == C_INCE) |=>
      (bus_we && bus_wdata == DW'($past(bus_rdata) + 1'b1)));

endmodule

// File: tb/tb_acc8_seq_core.sv
`timescale 1ns/1ps
module tb_acc8_seq_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr;
  logic        bus_we;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        trc_valid;
  logic [15:0] trc_addr;
  logic [7:0]  trc_data;
  logic        trc_write;
  logic [7:0]  acc_a;
  logic [15:0] idx_x;
  logic [15:0] prog_ctr;
  logic        illegal;

  always #2.5 clk = ~clk;

  acc8_seq_core dut (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .trc_valid(trc_valid), .trc_addr(trc_addr), .trc_data(trc_data),
    .trc_write(trc_write),
    .acc_a(acc_a), .idx_x(idx_x), .prog_ctr(prog_ctr), .illegal(illegal)
  );

  function automatic logic [12:0] ix(input logic [15:0] a);
    return {a[15], a[11:0]};
  endfunction

  logic [7:0]  mem [0:8191];
  logic        tb_clr = 1'b0;
  logic        tb_we  = 1'b0;
  logic [15:0] tb_a   = '0;
  logic [7:0]  tb_d   = '0;

  assign bus_rdata = mem[ix(bus_addr)];

  always @(posedge clk) begin
    if (tb_clr) begin
      for (int i = 0; i < 8192; i++) mem[i] <= 8'h00;
    end else if (tb_we) begin
      mem[ix(tb_a)] <= tb_d;
    end else if (bus_we) begin
      mem[ix(bus_addr)] <= bus_wdata;
    end
  end

  logic [15:0] tr_a [0:63];
  logic [7:0]  tr_d [0:63];
  logic        tr_w [0:63];
  int          tn = 0;
  logic        rec_clr = 1'b0;

  always @(negedge clk) begin
    if (rec_clr) tn <= 0;
    else if (trc_valid && tn < 64) begin
      tr_a[tn] <= trc_addr;
      tr_d[tn] <= trc_data;
      tr_w[tn] <= trc_write;
      tn <= tn + 1;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_tr(input int i, input logic [15:0] a, input logic [7:0] d,
                        input logic w, input string req);
    chk(tr_a[i] == a && tr_d[i] == d && tr_w[i] == w, req,
        $sformatf("trace[%0d] {addr,data,wr}", i),
        {7'd0, tr_a[i], tr_d[i], tr_w[i]}, {7'd0, a, d, w});
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    tb_we = 1'b1; tb_a = a; tb_d = d;
    @(posedge clk); #1;
    tb_we = 1'b0;
  endtask

  // hold reset, clear memory and trace, set vector to $F100
  task automatic setup();
    rst = 1'b1; rec_clr = 1'b1; tb_clr = 1'b1;
    @(posedge clk); #1;
    tb_clr = 1'b0;
    poke(16'hFFFE, 8'hF1);
    poke(16'hFFFF, 8'h00);
  endtask

  task automatic run(input int cycles);
    @(negedge clk);
    rec_clr = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    setup();
    poke(16'hF100, 8'h00);
    @(negedge clk);
    chk(illegal == 1'b0, "R1", "illegal during reset", illegal, 0);
    chk(trc_valid == 1'b0, "R1", "trace during reset", trc_valid, 0);
    run(20);
    chk(tn == 3, "R1", "trace count", tn, 3);
    chk_tr(0, 16'hFFFE, 8'hF1, 1'b0, "R1");
    chk_tr(1, 16'hFFFF, 8'h00, 1'b0, "R1");
    chk_tr(2, 16'hF100, 8'h00, 1'b0, "R2");
  endtask

  task automatic t_lda_imm();
    setup();
    poke(16'hF100, 8'h86); poke(16'hF101, 8'h24);
    run(20);
    chk(tn == 5, "R4", "ldaa # trace count", tn, 5);
    chk_tr(2, 16'hF100, 8'h86, 1'b0, "R2");
    chk_tr(3, 16'hF101, 8'h24, 1'b0, "R4");
    chk_tr(4, 16'hF102, 8'h00, 1'b0, "R4");
    chk(acc_a == 8'h24, "R4", "A after ldaa #", acc_a, 8'h24);
  endtask

  task automatic t_clra();
    setup();
    poke(16'hF100, 8'h86); poke(16'hF101, 8'h24); poke(16'hF102, 8'h87);
    run(20);
    chk(tn == 6, "R3", "clra trace count", tn, 6);
    chk_tr(4, 16'hF102, 8'h87, 1'b0, "R3");
    chk_tr(5, 16'hF103, 8'h00, 1'b0, "R3");
    chk(acc_a == 8'h00, "R3", "A after clra", acc_a, 0);
    chk(prog_ctr == 16'hF104, "R2", "PC after halt", prog_ctr, 16'hF104);
  endtask

  task automatic t_lda_dir();
    setup();
    poke(16'h0080, 8'h57);
    poke(16'hF100, 8'h96); poke(16'hF101, 8'h80);
    run(20);
    chk(tn == 6, "R5", "direct trace count", tn, 6);
    chk_tr(4, 16'h0080, 8'h57, 1'b0, "R5");
    chk(acc_a == 8'h57, "R5", "A after direct load", acc_a, 8'h57);
  endtask

  task automatic t_lda_ext();
    setup();
    poke(16'h0801, 8'h62);
    poke(16'hF100, 8'hB6); poke(16'hF101, 8'h08); poke(16'hF102, 8'h01);
    run(20);
    chk(tn == 7, "R6", "extended trace count", tn, 7);
    chk_tr(5, 16'h0801, 8'h62, 1'b0, "R6");
    chk_tr(6, 16'hF103, 8'h00, 1'b0, "R6");
    chk(acc_a == 8'h62, "R6", "A after extended load", acc_a, 8'h62);
  endtask

  task automatic t_ldx_ext();
    setup();
    poke(16'h0800, 8'h0D); poke(16'h0801, 8'h0A);
    poke(16'hF100, 8'hFE); poke(16'hF101, 8'h08); poke(16'hF102, 8'h00);
    run(20);
    chk(tn == 8, "R8", "ldx ext trace count", tn, 8);
    chk_tr(5, 16'h0800, 8'h0D, 1'b0, "R8");
    chk_tr(6, 16'h0801, 8'h0A, 1'b0, "R8");
    chk(idx_x == 16'h0D0A, "R8", "X after ldx ext", idx_x, 16'h0D0A);
  endtask

  task automatic t_stx();
    setup();
    poke(16'hF100, 8'hCE); poke(16'hF101, 8'h40); poke(16'hF102, 8'h1F);
    poke(16'hF103, 8'h7E); poke(16'hF104, 8'h08); poke(16'hF105, 8'h10);
    run(30);
    chk(idx_x == 16'h401F, "R7", "X after ldx #", idx_x, 16'h401F);
    chk(tn == 11, "R9", "stx trace count", tn, 11);
    chk_tr(4, 16'hF102, 8'h1F, 1'b0, "R7");
    chk_tr(8, 16'h0810, 8'h40, 1'b1, "R9");
    chk_tr(9, 16'h0811, 8'h1F, 1'b1, "R13");
    chk_tr(10, 16'hF106, 8'h00, 1'b0, "R9");
    chk(mem[ix(16'h0810)] == 8'h40, "R9", "memory $0810", mem[ix(16'h0810)], 8'h40);
    chk(mem[ix(16'h0811)] == 8'h1F, "R9", "memory $0811", mem[ix(16'h0811)], 8'h1F);
  endtask

  task automatic t_inc();
    setup();
    poke(16'h0820, 8'hFF);
    poke(16'hF100, 8'h72); poke(16'hF101, 8'h08); poke(16'hF102, 8'h20);
    run(20);
    chk(tn == 8, "R10", "inc trace count", tn, 8);
    chk_tr(5, 16'h0820, 8'hFF, 1'b0, "R10");
    chk_tr(6, 16'h0820, 8'h00, 1'b1, "R10");
    chk(mem[ix(16'h0820)] == 8'h00, "R10", "memory $0820 wrap", mem[ix(16'h0820)], 0);
  endtask

  task automatic t_bra();
    setup();
    poke(16'hF100, 8'h20); poke(16'hF101, 8'h5E);
    poke(16'hF160, 8'h20); poke(16'hF161, 8'hBE);
    poke(16'hF120, 8'h86); poke(16'hF121, 8'h55);
    run(30);
    chk(tn == 9, "R11", "branch trace count", tn, 9);
    chk_tr(4, 16'hF160, 8'h20, 1'b0, "R11");
    chk_tr(6, 16'hF120, 8'h86, 1'b0, "R11");
    chk_tr(8, 16'hF122, 8'h00, 1'b0, "R11");
    chk(acc_a == 8'h55, "R11", "A at branch target", acc_a, 8'h55);
    chk(prog_ctr == 16'hF123, "R12", "PC after halt", prog_ctr, 16'hF123);
  endtask

  task automatic t_illegal();
    setup();
    poke(16'hF100, 8'h86); poke(16'hF101, 8'h11); poke(16'hF102, 8'h01);
    run(15);
    chk(illegal == 1'b1, "R12", "illegal set", illegal, 1);
    chk(tn == 5, "R12", "trace count at halt", tn, 5);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(tn == 5, "R12", "no bus after halt", tn, 5);
    chk(illegal == 1'b1, "R12", "illegal held", illegal, 1);
    chk(acc_a == 8'h11, "R12", "A kept", acc_a, 8'h11);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(illegal == 1'b0, "R12", "illegal cleared by reset", illegal, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lda_imm();
    t_clra();
    t_lda_dir();
    t_lda_ext();
    t_ldx_ext();
    t_stx();
    t_inc();
    t_bra();
    t_illegal();
    done = 1;
    summary();
    $finish;
  end

endmodule